// File: doc/BRIEF.md
# OTP Programming Unlock Sequencer

This block stands between a one-time-programmable array controller's register port and its program path. Software announces each command by placing a command code and a data word on the port and raising a start strobe. The block watches for one particular ordered key of four data words. Each key word must arrive under the unlock command code, one word per started command. When the whole key has been entered, the block sets a programming-permitted flag. The flag stays set until a lock command or a reset.

Every started command completes with a one-cycle done pulse. This pulse and the permitted flag leave the block as bits of a small status vector, which the controller's status register decodes. A separate fire pulse goes to the array's program gate. It is raised only for a program command that is started while programming is permitted.

Top module: `otpu_unlock_seq`

## Requirements
- R1: After reset, every status bit reads 0 and `prog_fire` is 0.
- R2: Each rising edge of `start` produces a done pulse. The pulse appears in `status[1]` for exactly one cycle, in the cycle after the clock edge that saw `start` high for the first time. Every command code produces this pulse.
- R3: The key is the words 0xF, 0x4, 0x8 and 0xD, compared over the full data width and entered in that order. Each word is issued with command code 0x02. The permitted flag appears in `status[2]` in the same cycle as the done pulse of the fourth correct word.
- R4: Once set, `status[2]` stays 1 through any command other than the lock command. This includes unlock commands that carry wrong data.
- R5: If an unlock command (0x02) carries a word that differs from the expected key word, the match restarts from the first key word. The offending word is not counted as a first key word, and `status[2]` stays 0. A word that differs only in its upper bits counts as a mismatch.
- R6: Holding `start` high consumes only one step and produces one done pulse, even if the data changes while `start` is held.
- R7: The lock command (0x03) clears `status[2]` and also discards any partly entered key.
- R8: A program command (0x08) always produces a done pulse. It raises `prog_fire` alongside that pulse only while `status[2]` is 1. While the flag is 0, `prog_fire` stays 0.
- R9: Commands with any code other than 0x02 or 0x03, such as read (0x00) or program (0x08), leave the key progress and the flag unchanged. A key word issued under such a code does not advance the match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_code | input | CMD_W | Command code of the command being started |
| wr_data | input | DATA_W | Write-data word of the command |
| start | input | 1 | Start strobe; its rising edge starts a command |
| status | output | 3 | Bit 2 programming permitted, bit 1 command done, bit 0 reads 0 |
| prog_fire | output | 1 | One-cycle pulse allowing the array to program the addressed row |

## Verification
Two things change in the same cycle on the fourth key word: the done pulse and the rising permitted flag. The bench samples both from one read of `status` after that step and requires both bits to be set together. It also checks that neither bit was set one step early. A second coincidence is the fire pulse, which shares its cycle with the done pulse of a program command. The bench issues program commands just after an unlock and just after a lock. It judges fire and done from the same sample, so a flag that lags by a cycle would show up as a mismatch.

// File: rtl/otpu_pkg.sv
package otpu_pkg;

   localparam int unsigned KEY_MAX = 4;

   typedef enum logic [5:0] {
      OP_READ    = 6'h00,
      OP_UNLOCK  = 6'h02,
      OP_LOCK    = 6'h03,
      OP_PROGRAM = 6'h08
   } op_e;

   localparam int unsigned STAT_DONE_BIT = 1;
   localparam int unsigned STAT_OK_BIT   = 2;

   // Ordered unlock key; position matters.
   function automatic logic [31:0] key_word(input int idx);
      case (idx)
         0:       return 32'h0000_000F;
         1:       return 32'h0000_0004;
         2:       return 32'h0000_0008;
         3:       return 32'h0000_000D;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/otpu_edge.sv
module otpu_edge #(
   parameter bit SYNC_START = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic start_rise
);

   logic start_q;

   generate
      if (SYNC_START) begin : g_sync
         logic start_s;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               start_s <= 1'b0;
               start_q <= 1'b0;
            end else begin
               start_s <= start;
               start_q <= start_s;
            end
         end
         assign start_rise = start_s & ~start_q;
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) start_q <= 1'b0;
            else        start_q <= start;
         end
         assign start_rise = start & ~start_q;
      end
   endgenerate

   // R6: a held strobe never yields two consecutive steps
   p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_rise |=> !start_rise);

endmodule

// File: rtl/otpu_key_match.sv
module otpu_key_match #(
   parameter int unsigned CMD_W   = 6,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned KEY_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [DATA_W-1:0] data,
   output logic              unlocked
);

   localparam int unsigned PTR_W = $clog2(KEY_LEN);
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(KEY_LEN - 1);
   localparam logic [CMD_W-1:0] C_UNLOCK = CMD_W'(otpu_pkg::OP_UNLOCK);
   localparam logic [CMD_W-1:0] C_LOCK   = CMD_W'(otpu_pkg::OP_LOCK);

   logic [DATA_W-1:0] key_tab [KEY_LEN];

   for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
      assign key_tab[g] = DATA_W'(otpu_pkg::key_word(g));
   end

   logic [PTR_W-1:0] ptr;
   logic             is_en, is_dis, hit, last;

   assign is_en  = (cmd == C_UNLOCK);
   assign is_dis = (cmd == C_LOCK);
   assign hit    = (data == key_tab[ptr]);
   assign last   = (ptr == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         unlocked <= 1'b0;
      end else if (step) begin
         if (is_dis) begin
            ptr      <= '0;
            unlocked <= 1'b0;
         end else if (is_en) begin
            if (!hit) begin
               ptr <= '0;
            end else if (last) begin
               ptr      <= '0;
               unlocked <= 1'b1;
            end else begin
               ptr <= ptr + PTR_W'(1);
            end
         end
      end
   end

   // R3: the flag only rises on a step carrying the final key word
   p_rise_on_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked) |-> ($past(step) && $past(data) == key_tab[KEY_LEN-1]));

   // R4: the flag holds unless a lock command steps
   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && !(step && is_dis)) |=> unlocked);

   // R5: a mismatching unlock word restarts the match
   p_miss_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && is_en && !hit) |=> (ptr == '0 && $stable(unlocked)));

   // R7: lock clears flag and progress
   p_lock_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && is_dis) |=> (!unlocked && ptr == '0));

   // R9: other codes touch nothing
   p_other_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !is_en && !is_dis) |=> ($stable(ptr) && $stable(unlocked)));

endmodule

// File: rtl/otpu_unlock_seq.sv
module otpu_unlock_seq #(
   parameter int unsigned CMD_W      = 6,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned KEY_LEN    = 4,
   parameter bit          SYNC_START = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CMD_W-1:0]  cmd_code,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              start,
   output logic [2:0]        status,
   output logic              prog_fire
);

   localparam logic [CMD_W-1:0] C_PROGRAM = CMD_W'(otpu_pkg::OP_PROGRAM);

   generate
      if (KEY_LEN < 2 || KEY_LEN > otpu_pkg::KEY_MAX) begin : g_bad_key
         $error("otpu_unlock_seq: KEY_LEN out of range");
      end
      if (CMD_W < 4) begin : g_bad_cmd
         $error("otpu_unlock_seq: CMD_W too narrow for command codes");
      end
      if (DATA_W < 4) begin : g_bad_data
         $error("otpu_unlock_seq: DATA_W too narrow for key words");
      end
   endgenerate

   logic step, unlocked, done_q, fire_q;

   otpu_edge #(.SYNC_START(SYNC_START)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_rise (step)
   );

   otpu_key_match #(
      .CMD_W   (CMD_W),
      .DATA_W  (DATA_W),
      .KEY_LEN (KEY_LEN)
   ) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .cmd      (cmd_code),
      .data     (wr_data),
      .unlocked (unlocked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         fire_q <= 1'b0;
      end else begin
         done_q <= step;
         fire_q <= step && (cmd_code == C_PROGRAM) && unlocked;
      end
   end

   always_comb begin
      status = '0;
      status[otpu_pkg::STAT_DONE_BIT] = done_q;
      status[otpu_pkg::STAT_OK_BIT]   = unlocked;
   end
   assign prog_fire = fire_q;

   // R2: done is a single-cycle pulse
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      status[1] |=> !status[1]);

   // R8: fire only with done and while permitted
   p_fire_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      prog_fire |-> (status[1] && status[2]));

endmodule

// File: tb/otpu_unlock_seq_test.sv
module otpu_unlock_seq_test;

   localparam time CLK_P = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  cmd_code = '0;
   logic [31:0] wr_data = '0;
   logic        start = 1'b0;
   logic [2:0]  status;
   logic        prog_fire;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   otpu_unlock_seq uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_code  (cmd_code),
      .wr_data   (wr_data),
      .start     (start),
      .status    (status),
      .prog_fire (prog_fire)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [5:0] c, input logic [31:0] d,
                        output logic dn, output logic ok, output logic fr);
      @(negedge clk);
      cmd_code = c; wr_data = d; start = 1'b1;
      @(negedge clk);
      dn = status[1]; ok = status[2]; fr = prog_fire;
      start = 1'b0;
      @(negedge clk);
   endtask

   task automatic enter_key(output logic ok);
      logic dn, fr;
      issue(6'h02, 32'hF, dn, ok, fr);
      issue(6'h02, 32'h4, dn, ok, fr);
      issue(6'h02, 32'h8, dn, ok, fr);
      issue(6'h02, 32'hD, dn, ok, fr);
   endtask

   task automatic lock_it();
      logic dn, ok, fr;
      issue(6'h03, 32'h0, dn, ok, fr);
   endtask

   task automatic t_reset();
      chk("R1 status", 32'(status), 32'h0);
      chk("R1 fire", 32'(prog_fire), 32'h0);
   endtask

   task automatic t_unlock();
      logic dn, ok, fr;
      issue(6'h02, 32'hF, dn, ok, fr);
      chk("R2 done step1", 32'(dn), 32'h1);
      chk("R3 not yet step1", 32'(ok), 32'h0);
      chk("R2 done falls", 32'(status[1]), 32'h0);
      issue(6'h02, 32'h4, dn, ok, fr);
      issue(6'h02, 32'h8, dn, ok, fr);
      chk("R3 not yet step3", 32'(ok), 32'h0);
      issue(6'h02, 32'hD, dn, ok, fr);
      chk("R3 done with unlock", 32'(dn), 32'h1);
      chk("R3 unlocked", 32'(ok), 32'h1);
   endtask

   task automatic t_sticky_program();
      logic dn, ok, fr;
      issue(6'h00, 32'h0, dn, ok, fr);
      chk("R4 after read", 32'(ok), 32'h1);
      issue(6'h02, 32'h55, dn, ok, fr);
      chk("R4 after bad unlock word", 32'(ok), 32'h1);
      issue(6'h08, 32'h1234, dn, ok, fr);
      chk("R8 done unlocked", 32'(dn), 32'h1);
      chk("R8 fire unlocked", 32'(fr), 32'h1);
      chk("R8 fire falls", 32'(prog_fire), 32'h0);
   endtask

   task automatic t_lock();
      logic dn, ok, fr;
      issue(6'h03, 32'h0, dn, ok, fr);
      chk("R7 lock done", 32'(dn), 32'h1);
      chk("R7 lock clears", 32'(ok), 32'h0);
      issue(6'h08, 32'h1234, dn, ok, fr);
      chk("R8 done locked", 32'(dn), 32'h1);
      chk("R8 no fire locked", 32'(fr), 32'h0);
   endtask

   task automatic t_partial_lock();
      logic dn, ok, fr;
      issue(6'h02, 32'hF, dn, ok, fr);
      issue(6'h02, 32'h4, dn, ok, fr);
      issue(6'h03, 32'h0, dn, ok, fr);
      issue(6'h02, 32'h8, dn, ok, fr);
      issue(6'h02, 32'hD, dn, ok, fr);
      chk("R7 progress discarded", 32'(ok), 32'h0);
   endtask

   task automatic t_wrong();
      logic dn, ok, fr;
      issue(6'h02, 32'hF, dn, ok, fr);
      issue(6'h02, 32'h4, dn, ok, fr);
      issue(6'h02, 32'hF, dn, ok, fr);
      issue(6'h02, 32'h4, dn, ok, fr);
      issue(6'h02, 32'h8, dn, ok, fr);
      issue(6'h02, 32'hD, dn, ok, fr);
      chk("R5 restart not counted", 32'(ok), 32'h0);
      issue(6'h02, 32'h1000_000F, dn, ok, fr);
      issue(6'h02, 32'h4, dn, ok, fr);
      issue(6'h02, 32'h8, dn, ok, fr);
      issue(6'h02, 32'hD, dn, ok, fr);
      chk("R5 upper bits mismatch", 32'(ok), 32'h0);
      enter_key(ok);
      chk("R5 clean key after restart", 32'(ok), 32'h1);
      lock_it();
   endtask

   task automatic t_hold();
      logic dn, ok, fr;
      int pulses = 0;
      @(negedge clk);
      cmd_code = 6'h02; wr_data = 32'hF; start = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (status[1]) pulses++;
         wr_data = (i == 1) ? 32'h4 : (i == 2) ? 32'h8 : 32'hD;
      end
      start = 1'b0;
      @(negedge clk);
      if (status[1]) pulses++;
      chk("R6 one pulse while held", 32'(pulses), 32'h1);
      chk("R6 no unlock while held", 32'(status[2]), 32'h0);
      issue(6'h02, 32'h4, dn, ok, fr);
      issue(6'h02, 32'h8, dn, ok, fr);
      issue(6'h02, 32'hD, dn, ok, fr);
      chk("R6 held step counted once", 32'(ok), 32'h1);
      lock_it();
   endtask

   task automatic t_other();
      logic dn, ok, fr;
      issue(6'h02, 32'hF, dn, ok, fr);
      issue(6'h02, 32'h4, dn, ok, fr);
      issue(6'h00, 32'h8, dn, ok, fr);
      chk("R2 done on read", 32'(dn), 32'h1);
      issue(6'h08, 32'hD, dn, ok, fr);
      issue(6'h02, 32'h8, dn, ok, fr);
      issue(6'h02, 32'hD, dn, ok, fr);
      chk("R9 other codes keep progress", 32'(ok), 32'h1);
      lock_it();
      issue(6'h00, 32'hF, dn, ok, fr);
      issue(6'h02, 32'h4, dn, ok, fr);
      issue(6'h02, 32'h8, dn, ok, fr);
      issue(6'h02, 32'hD, dn, ok, fr);
      chk("R9 key word under read ignored", 32'(ok), 32'h0);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unlock();
      t_sticky_program();
      t_lock();
      t_partial_lock();
      t_wrong();
      t_hold();
      t_other();
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
   end

endmodule